// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block is the host-facing serial port of a configurable peripheral. A host drives a four-wire SPI link (clock idle low, data captured on the rising clock edge) and reaches three kinds of targets through one 7-bit address space: a bank of 16-bit configuration words, a set of command-strobe addresses that fire single-cycle pulses, and a byte-wide port into an external FIFO. Every frame opens with an 8-bit header: a read/write flag and a 7-bit address. While the header shifts in, the block shifts out a status byte built from four live condition inputs.

After the header, a register access moves 16 data bits, and it repeats on the same register for as long as chip select stays low. A strobe access moves no data. A FIFO access streams bytes, pushing or popping one entry per byte. The serial pins are oversampled in the system clock domain. The configuration words are exposed as a flat bus for the logic they control.

Top module: `cfg_spi_slave`

## Requirements
- R1: The header is the first 8 bits of a frame, sampled on rising SCLK edges while CSn is low: bit one is R/W (0 write, 1 read), then address bits A6 down to A0. A frame with R/W = 1 never changes a register.
- R2: A register write takes its 16 data bits D15 first, and the register changes only once D0 has been sampled. A frame that ends earlier leaves the register unchanged.
- R3: A register read drives the stored word on MISO D15 first. MISO changes after falling SCLK edges, and a read may end after the upper 8 bits.
- R4: During the header, MISO carries a status byte captured when CSn falls, MSB first: bit 6 oscillator stable, bit 4 sync found, bit 3 CRC pass, bit 2 synthesizer locked. Bits 7, 5, 1 and 0 read as 0, and bit 7 is valid before the first rising edge.
- R5: A header naming address STROBE_BASE+k (0x60..0x68 by default) gives one clock-cycle pulse on strobe_o[k], and only on that bit. Strobe addresses change no register and read as 0x0000.
- R6: While CSn stays low after a 16-bit data word, each further 16 bits access the same register without a new header.
- R7: A write frame to FIFO_ADDR (0x70) produces one fifo_push with the byte on fifo_wdata after every 8 data bits, MSB first.
- R8: A read frame to FIFO_ADDR shows the head byte during each 8-bit slot and pops it when the slot completes, streaming until CSn rises.
- R9: A FIFO byte written while fifo_full, or read while fifo_empty (which then returns 0x00), is dropped and sets fifo_err. fifo_err stays set until reset.
- R10: spi_miso_oe is low whenever CSn has been high for more than SYNC_STAGES clock cycles, and high during a frame.
- R11: Addresses that are neither registers, strobes nor the FIFO read as 0x0000, and writes to them change no register.
- R12: Addresses 0 to NUM_REGS-1 are the registers. Register k appears on cfg_flat[16k+15:16k] and resets to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| st_osc_stable | input | 1 | Status: oscillator stable |
| st_sync_found | input | 1 | Status: sync word found |
| st_crc_pass | input | 1 | Status: CRC pass |
| st_synth_locked | input | 1 | Status: synthesizer locked |
| cfg_flat | output | NUM_REGS*16 | All configuration words, register k at bits 16k+15:16k |
| strobe_o | output | NUM_STROBES | Single-cycle command pulses |
| fifo_push | output | 1 | Push one byte into the external FIFO |
| fifo_wdata | output | 8 | Byte to push |
| fifo_full | input | 1 | External FIFO full |
| fifo_pop | output | 1 | Pop the head byte of the external FIFO |
| fifo_rdata | input | 8 | Head byte of the external FIFO |
| fifo_empty | input | 1 | External FIFO empty |
| fifo_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench builds the block with its default parameters: 44 registers, nine strobes from 0x60, the FIFO port at 0x70 and two synchronizer stages. With these values it can reach the last register 0x2B, the first hole 0x2C, and both the first and last strobe with the hole just past them. The external FIFO is a bench model only four entries deep, so a five-byte burst reaches overflow and a read after reset reaches underflow. SCLK runs at twelve system clocks per bit, which leaves the synchronizer and the load-before-falling-edge path enough margin.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_REG    = 2'd1,
    ACC_STROBE = 2'd2,
    ACC_FIFO   = 2'd3
  } acc_cls_e;

  // Which target an address reaches.
  function automatic acc_cls_e classify(input logic [6:0] a, input int nregs,
                                        input int sbase, input int nstr,
                                        input int faddr);
    int ai;
    ai = int'(a);
    if (ai < nregs)                          return ACC_REG;
    else if (ai >= sbase && ai < sbase+nstr) return ACC_STROBE;
    else if (ai == faddr)                    return ACC_FIFO;
    else                                     return ACC_NONE;
  endfunction

  // Status byte returned during the header.
  function automatic logic [7:0] pack_status(input logic osc, input logic sync,
                                             input logic crc, input logic lock);
    return {1'b0, osc, 1'b0, sync, crc, lock, 2'b00};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_csn,
  input  logic spi_mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_start,
  output logic mosi_s
);
  logic [STAGES-1:0] sclk_ff, csn_ff, mosi_ff;
  logic sclk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_ff <= '0;
      csn_ff  <= '1;
      mosi_ff <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      sclk_ff[0] <= spi_sclk;
      csn_ff[0]  <= spi_csn;
      mosi_ff[0] <= spi_mosi;
      for (int i = 1; i < STAGES; i++) begin
        sclk_ff[i] <= sclk_ff[i-1];
        csn_ff[i]  <= csn_ff[i-1];
        mosi_ff[i] <= mosi_ff[i-1];
      end
      sclk_q <= sclk_ff[STAGES-1];
      cs_q   <= cs_act;
    end
  end

  assign cs_act    = ~csn_ff[STAGES-1];
  assign cs_start  = cs_act & ~cs_q;
  assign mosi_s    = mosi_ff[STAGES-1];
  assign sclk_rise = cs_act &  sclk_ff[STAGES-1] & ~sclk_q;
  assign sclk_fall = cs_act & ~sclk_ff[STAGES-1] &  sclk_q;

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_start,
  input  logic              rise,
  input  logic              mosi,
  input  logic              byte_mode,
  output logic              hdr_done,
  output logic              word_done,
  output logic              hdr_rw,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic [WORD_W-1:0] word_data
);
  localparam int HDR_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] rx_sh;
  logic [CNT_W-1:0]  cnt;
  logic              in_hdr;
  logic [CNT_W-1:0]  last_bit;

  assign last_bit = byte_mode ? CNT_W'(BYTE_W-1) : CNT_W'(WORD_W-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh     <= '0;
      cnt       <= '0;
      in_hdr    <= 1'b1;
      hdr_done  <= 1'b0;
      word_done <= 1'b0;
      hdr_rw    <= 1'b0;
      hdr_addr  <= '0;
      word_data <= '0;
    end else begin
      hdr_done  <= 1'b0;
      word_done <= 1'b0;
      if (cs_start) begin
        in_hdr <= 1'b1;
        cnt    <= '0;
      end else if (rise) begin
        rx_sh <= {rx_sh[WORD_W-2:0], mosi};
        if (in_hdr) begin
          if (cnt == CNT_W'(HDR_W-1)) begin
            in_hdr   <= 1'b0;
            cnt      <= '0;
            hdr_rw   <= rx_sh[ADDR_W-1];
            hdr_addr <= {rx_sh[ADDR_W-2:0], mosi};
            hdr_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == last_bit) begin
          cnt       <= '0;
          word_done <= 1'b1;
          word_data <= {rx_sh[WORD_W-2:0], mosi};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_hdr_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> $past(rise));
  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_done && word_done));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NUM_REGS = 44,
  parameter int ADDR_W   = 7,
  parameter int WORD_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_idx,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_idx,
  output logic [WORD_W-1:0]          rd_data,
  output logic [NUM_REGS*WORD_W-1:0] cfg_flat
);
  logic [WORD_W-1:0] regs [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   regs[k] <= '0;
      else if (wr_en && wr_idx == ADDR_W'(k))       regs[k] <= wr_data;
    end
    assign cfg_flat[k*WORD_W +: WORD_W] = regs[k];

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && wr_idx == ADDR_W'(k)) |-> $stable(regs[k]));
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_idx == ADDR_W'(k)) rd_data = regs[k];
  end

endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfgspi_pkg::*;
#(
  parameter int NUM_REGS    = 44,
  parameter int NUM_STROBES = 9,
  parameter int STROBE_BASE = 'h60,
  parameter int FIFO_ADDR   = 'h70,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_csn,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  output logic                   spi_miso_oe,
  input  logic                   st_osc_stable,
  input  logic                   st_sync_found,
  input  logic                   st_crc_pass,
  input  logic                   st_synth_locked,
  output logic [NUM_REGS*16-1:0] cfg_flat,
  output logic [NUM_STROBES-1:0] strobe_o,
  output logic                   fifo_push,
  output logic [7:0]             fifo_wdata,
  input  logic                   fifo_full,
  output logic                   fifo_pop,
  input  logic [7:0]             fifo_rdata,
  input  logic                   fifo_empty,
  output logic                   fifo_err
);
  localparam int ADDR_W = 7;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Named internal events
  logic              sclk_rise, sclk_fall, cs_act, cs_start, mosi_s;
  logic              hdr_done, word_done, hdr_rw;
  logic [ADDR_W-1:0] hdr_addr;
  logic [WORD_W-1:0] word_data, reg_rd;
  acc_cls_e          cls;
  logic              fifo_rd, load_now, rd_valid, rd_pend, reg_wr;
  logic [WORD_W-1:0] tx_sh, load_val;
  logic [7:0]        status_now;
  logic              miso_q;
  logic [NUM_STROBES-1:0] strobe_hit;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .cs_start(cs_start), .mosi_s(mosi_s));

  assign cls = classify(hdr_addr, NUM_REGS, STROBE_BASE, NUM_STROBES, FIFO_ADDR);

  spi_frame_engine #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rise(sclk_rise),
    .mosi(mosi_s), .byte_mode(cls == ACC_FIFO), .hdr_done(hdr_done),
    .word_done(word_done), .hdr_rw(hdr_rw), .hdr_addr(hdr_addr),
    .word_data(word_data));

  assign reg_wr = word_done && !hdr_rw && cls == ACC_REG;

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(hdr_addr),
    .wr_data(word_data), .rd_idx(hdr_addr), .rd_data(reg_rd),
    .cfg_flat(cfg_flat));

  // FIFO port handshakes
  assign fifo_rd    = cls == ACC_FIFO && hdr_rw;
  assign fifo_push  = word_done && cls == ACC_FIFO && !hdr_rw && !fifo_full;
  assign fifo_wdata = word_data[BYTE_W-1:0];
  assign fifo_pop   = word_done && fifo_rd && rd_valid;

  // Shift-out path
  assign status_now = pack_status(st_osc_stable, st_sync_found, st_crc_pass, st_synth_locked);
  assign load_now   = hdr_done || rd_pend || (word_done && !fifo_rd);

  always_comb begin
    if (fifo_rd)             load_val = {(fifo_empty ? 8'h00 : fifo_rdata), 8'h00};
    else if (cls == ACC_REG) load_val = reg_rd;
    else                     load_val = '0;
  end

  always_comb
    for (int k = 0; k < NUM_STROBES; k++)
      strobe_hit[k] = (int'(hdr_addr) == STROBE_BASE + k);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      miso_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_pend  <= 1'b0;
      fifo_err <= 1'b0;
      strobe_o <= '0;
    end else begin
      rd_pend  <= word_done && fifo_rd;
      strobe_o <= (hdr_done && cls == ACC_STROBE) ? strobe_hit : '0;
      if (word_done && cls == ACC_FIFO &&
          ((hdr_rw && !rd_valid) || (!hdr_rw && fifo_full)))
        fifo_err <= 1'b1;
      if (cs_start) begin
        miso_q <= status_now[7];
        tx_sh  <= {status_now[6:0], {(WORD_W-7){1'b0}}};
      end else if (load_now) begin
        tx_sh <= load_val;
        if (fifo_rd) rd_valid <= !fifo_empty;
      end else if (sclk_fall) begin
        miso_q <= tx_sh[WORD_W-1];
        tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign spi_miso    = miso_q;
  assign spi_miso_oe = cs_act;

  // Checker state: cycles CSn has been high at the pin
  logic [2:0] csn_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                csn_hi_cnt <= '0;
    else if (!spi_csn)         csn_hi_cnt <= '0;
    else if (csn_hi_cnt != 3'd7) csn_hi_cnt <= csn_hi_cnt + 1'b1;
  end

  assert_miso_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(csn_hi_cnt) > SYNC_STAGES) |-> !spi_miso_oe);
  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_o));
  assert_strobe_from_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe_o) |-> $past(hdr_done));
  assert_push_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> $past(sclk_rise));
  assert_pop_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> $past(sclk_rise));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_err |=> fifo_err);

endmodule

// File: tb/cfg_spi_slave_tb_top.sv
module cfg_spi_slave_tb_top;
  localparam int NREG = 44;
  localparam int H    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic st_osc, st_sync, st_crc, st_lock;
  logic [NREG*16-1:0] cfg_flat;
  logic [8:0] strobe_o;
  logic fifo_push, fifo_pop, fifo_full, fifo_empty, fifo_err;
  logic [7:0] fifo_wdata, fifo_rdata;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cfg_spi_slave #(.NUM_REGS(NREG), .NUM_STROBES(9), .STROBE_BASE('h60),
                  .FIFO_ADDR('h70), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .st_osc_stable(st_osc), .st_sync_found(st_sync), .st_crc_pass(st_crc),
    .st_synth_locked(st_lock), .cfg_flat(cfg_flat), .strobe_o(strobe_o),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .fifo_err(fifo_err));

  // External FIFO model, 4 entries
  logic [7:0] fmem [4];
  logic [1:0] frd, fwr;
  logic [2:0] fcnt;
  int push_total = 0, pop_total = 0;
  assign fifo_full  = (fcnt == 3'd4);
  assign fifo_empty = (fcnt == 3'd0);
  assign fifo_rdata = fmem[frd];

  always @(posedge clk) begin
    if (!rst_n) begin
      frd <= '0; fwr <= '0; fcnt <= '0;
      for (int i = 0; i < 4; i++) fmem[i] <= 8'h00;
    end else begin
      if (fifo_push && fcnt != 3'd4) begin
        fmem[fwr] <= fifo_wdata; fwr <= fwr + 1'b1; push_total <= push_total + 1;
      end
      if (fifo_pop && fcnt != 3'd0) begin
        frd <= frd + 1'b1; pop_total <= pop_total + 1;
      end
      fcnt <= fcnt + 3'((fifo_push && fcnt != 3'd4) ? 1 : 0)
                   - 3'((fifo_pop && fcnt != 3'd0) ? 1 : 0);
    end
  end

  // Strobe monitor
  int strobe_cycles = 0;
  logic [8:0] strobe_seen = '0;
  always @(posedge clk)
    if (rst_n && |strobe_o) begin
      strobe_cycles <= strobe_cycles + 1;
      strobe_seen   <= strobe_seen | strobe_o;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cfgw(input int k);
    return cfg_flat[k*16 +: 16];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic spi_open();
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_close();
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (3*H) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [15:0] v, input int n, output logic [15:0] got);
    got = '0;
    for (int i = n-1; i >= 0; i--) begin
      spi_mosi = v[i];
      repeat (H) @(negedge clk);
      got[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic hdr(input logic rw, input logic [6:0] a, output logic [7:0] st);
    logic [15:0] g;
    spi_bits({8'h00, rw, a}, 8, g);
    st = g[7:0];
  endtask

  task automatic wreg(input logic [6:0] a, input logic [15:0] d);
    logic [7:0] st; logic [15:0] g;
    spi_open(); hdr(1'b0, a, st); spi_bits(d, 16, g); spi_close();
  endtask

  task automatic rreg(input logic [6:0] a, output logic [15:0] d, output logic [7:0] st);
    spi_open(); hdr(1'b1, a, st); spi_bits(16'h0000, 16, d); spi_close();
  endtask

  task automatic t_reset();
    chk("R12 cfg reset zero", 32'(|cfg_flat), 0);
    chk("R5 no strobe at reset", 32'(strobe_o), 0);
    chk("R9 err clear at reset", 32'(fifo_err), 0);
    chk("R10 oe low at reset", 32'(spi_miso_oe), 0);
  endtask

  task automatic t_write_read();
    logic [15:0] d; logic [7:0] st;
    st_osc = 1; st_sync = 0; st_crc = 1; st_lock = 1;
    wreg(7'd5, 16'hA5C3);
    chk("R2 write reg5", 32'(cfgw(5)), 32'h0000_A5C3);
    rreg(7'd5, d, st);
    chk("R3 read reg5", 32'(d), 32'h0000_A5C3);
    chk("R4 status 4C", 32'(st), 32'h4C);
    chk("R1 read frame keeps reg5", 32'(cfgw(5)), 32'h0000_A5C3);
    wreg(7'd43, 16'h0F0F);
    chk("R12 last reg written", 32'(cfgw(43)), 32'h0F0F);
    rreg(7'd43, d, st);
    chk("R12 last reg read", 32'(d), 32'h0F0F);
  endtask

  task automatic t_status2();
    logic [15:0] d; logic [7:0] st;
    st_osc = 0; st_sync = 1; st_crc = 0; st_lock = 0;
    rreg(7'd5, d, st);
    chk("R4 status 10", 32'(st), 32'h10);
    st_osc = 1; st_sync = 1; st_crc = 1; st_lock = 1;
    rreg(7'd5, d, st);
    chk("R4 status 5C", 32'(st), 32'h5C);
  endtask

  task automatic t_partial();
    logic [7:0] st; logic [15:0] g;
    spi_open(); hdr(1'b0, 7'd7, st); spi_bits(16'h03FF, 10, g); spi_close();
    chk("R2 partial write ignored", 32'(cfgw(7)), 0);
  endtask

  task automatic t_short_read();
    logic [7:0] st; logic [15:0] g;
    spi_open();
    chk("R10 oe high in frame", 32'(spi_miso_oe), 1);
    hdr(1'b1, 7'd5, st); spi_bits(16'h0000, 8, g); spi_close();
    chk("R3 high byte only", 32'(g[7:0]), 32'hA5);
    chk("R10 oe low after frame", 32'(spi_miso_oe), 0);
  endtask

  task automatic t_repeat();
    logic [7:0] st; logic [15:0] g1, g2;
    spi_open(); hdr(1'b0, 7'd9, st);
    spi_bits(16'h1111, 16, g1);
    repeat (4) @(negedge clk);
    chk("R6 first word", 32'(cfgw(9)), 32'h1111);
    spi_bits(16'h2222, 16, g1);
    spi_close();
    chk("R6 second word same reg", 32'(cfgw(9)), 32'h2222);
    chk("R6 neighbour untouched", 32'(cfgw(10)), 0);
    spi_open(); hdr(1'b1, 7'd9, st);
    spi_bits(16'h0, 16, g1); spi_bits(16'h0, 16, g2); spi_close();
    chk("R6 repeat read 1", 32'(g1), 32'h2222);
    chk("R6 repeat read 2", 32'(g2), 32'h2222);
  endtask

  task automatic t_unimpl();
    logic [NREG*16-1:0] snap; logic [15:0] d; logic [7:0] st;
    snap = cfg_flat;
    wreg(7'h2C, 16'hFFFF);
    wreg(7'h50, 16'hFFFF);
    chk("R11 hole writes ignored", 32'(cfg_flat == snap), 1);
    rreg(7'h2C, d, st);
    chk("R11 hole 2C reads 0", 32'(d), 0);
    rreg(7'h7F, d, st);
    chk("R11 hole 7F reads 0", 32'(d), 0);
  endtask

  task automatic t_strobe();
    logic [NREG*16-1:0] snap; logic [15:0] d; logic [7:0] st;
    snap = cfg_flat;
    spi_open(); hdr(1'b0, 7'h63, st); spi_close();
    chk("R5 one pulse cycle", 32'(strobe_cycles), 1);
    chk("R5 pulse on bit3", 32'(strobe_seen), 32'h008);
    chk("R5 strobe keeps regs", 32'(cfg_flat == snap), 1);
    rreg(7'h63, d, st);
    chk("R5 strobe reads 0", 32'(d), 0);
    spi_open(); hdr(1'b0, 7'h68, st); spi_close();
    chk("R5 last strobe bit8", 32'(strobe_seen), 32'h108);
    spi_open(); hdr(1'b0, 7'h69, st); spi_close();
    chk("R5 past last strobe no pulse", 32'(strobe_cycles), 3);
  endtask

  task automatic t_fifo();
    logic [7:0] st; logic [15:0] g, b0, b1, b2;
    spi_open(); hdr(1'b0, 7'h70, st);
    spi_bits(16'h11, 8, g); spi_bits(16'h22, 8, g); spi_bits(16'h33, 8, g);
    spi_close();
    chk("R7 three pushes", 32'(push_total), 3);
    chk("R7 fifo holds 3", 32'(fcnt), 3);
    chk("R7 head byte", 32'(fifo_rdata), 32'h11);
    spi_open(); hdr(1'b1, 7'h70, st);
    spi_bits(16'h0, 8, b0); spi_bits(16'h0, 8, b1); spi_bits(16'h0, 8, b2);
    spi_close();
    chk("R8 byte0", 32'(b0[7:0]), 32'h11);
    chk("R8 byte1", 32'(b1[7:0]), 32'h22);
    chk("R8 byte2", 32'(b2[7:0]), 32'h33);
    chk("R8 three pops", 32'(pop_total), 3);
    chk("R9 no err on exact drain", 32'(fifo_err), 0);
    spi_open(); hdr(1'b0, 7'h70, st);
    for (int i = 0; i < 5; i++) spi_bits(16'(8'hA0 + i), 8, g);
    spi_close();
    chk("R9 overflow dropped", 32'(fcnt), 4);
    chk("R9 overflow err", 32'(fifo_err), 1);
    spi_open(); hdr(1'b1, 7'h70, st);
    for (int i = 0; i < 4; i++) begin
      spi_bits(16'h0, 8, g);
      chk("R8 stream byte", 32'(g[7:0]), 32'(8'hA0 + i));
    end
    spi_close();
    chk("R9 err sticky", 32'(fifo_err), 1);
  endtask

  task automatic t_underflow();
    logic [7:0] st; logic [15:0] g;
    do_reset();
    chk("R9 err cleared by reset", 32'(fifo_err), 0);
    spi_open(); hdr(1'b1, 7'h70, st); spi_bits(16'h0, 8, g); spi_close();
    chk("R9 underflow byte 0", 32'(g[7:0]), 0);
    chk("R9 underflow err", 32'(fifo_err), 1);
    chk("R9 underflow no pop", 32'(fcnt), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    st_osc = 0; st_sync = 0; st_crc = 0; st_lock = 0;
    do_reset();
    t_reset();
    t_write_read();
    t_status2();
    t_partial();
    t_short_read();
    t_repeat();
    t_unimpl();
    t_strobe();
    t_fifo();
    t_underflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule